// File: doc/BRIEF.md
# Packed Word Multiply and Multiply-Add Unit

This unit takes two 64-bit operands, each seen as four 16-bit lanes, and multiplies every lane of the first operand by the lane in the same position of the second. Each lane product is 32 bits wide. A mode input picks what leaves the unit: the low 16 bits of each product, the signed high 16 bits of each product, or two 32-bit sums where each sum adds a neighbouring pair of signed products. Two more modes do no multiplying. They interleave words from the low or high half of both operands, so that a low-half result and a high-half result can be joined back into full 32-bit products.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The data path has two register stages. When the result side is ready on every cycle, one operand pair is taken per cycle and each result appears two cycles after its input. If the result side holds ready low, the offered result and its data stay fixed until they are taken. The pipeline stops taking input once both stages hold data. Results come out in the order their inputs were accepted, and none is lost or repeated.

Top module: `lane_mul_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, out_valid is 0 and in_ready is 1.
- R2: Mode 0 (in_mode = 3'd0): result lane i (bits 16i+15:16i) is bits 15:0 of the product of operand lanes a_i and b_i. For example, 0x0AB7 times 0x03F3 gives 0x50B5, and 0x01AC times 0x0006 gives 0x0A08.
- R3: Mode 1 (in_mode = 3'd1): result lane i is bits 31:16 of the signed two's-complement product of a_i and b_i. For example, 0x0AB7 times 0x03F3 gives 0x002A, and 0xFFFF times 0x0001 gives 0xFFFF.
- R4: Mode 2 (in_mode = 3'd2): result bits 31:0 are the signed sum p0+p1 and bits 63:32 are p2+p3, where pi is the signed product of lane i. Each sum wraps modulo 2^32. When all four inputs are 0x8000, each sum is 0x80000000.
- R5: Mode 3 (in_mode = 3'd3): the result words, from bit 0 upward, are a_0, b_0, a_1, b_1.
- R6: Mode 4 (in_mode = 3'd4): the result words, from bit 0 upward, are a_2, b_2, a_3, b_3.
- R7: in_mode values 5, 6 and 7 give an all-zero result.
- R8: An input is accepted on a clock edge where in_valid and in_ready are both 1. If out_ready is held at 1, the result is valid on the second cycle after the input cycle, and inputs are accepted on every cycle.
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged. When out_ready is 1, in_ready is 1. With the output stalled, in_ready falls after two more inputs are accepted. Results leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and mode are offered |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| in_mode | input | 3 | Operation select (see R2 to R7) |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result is offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result |

## Verification
The bench targets the signed edges of the multiplier. It applies 0x8000 in every lane in multiply-add mode: a design that saturates would return 0x7FFFFFFF instead of wrapping. It also pairs negative lanes with positive ones in high-half mode: an unsigned multiplier would lose the sign-extension ones in those lanes. The known example products are followed by both interleave modes, which catch a swapped word order or a half taken from the wrong place. Random stalls on out_ready catch a pipeline that drops, repeats or reorders results under back-pressure, or that lets the offered data change while it waits.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_MUL_LO = 3'd0,
    MODE_MUL_HI = 3'd1,
    MODE_MADD   = 3'd2,
    MODE_ILV_LO = 3'd3,
    MODE_ILV_HI = 3'd4
  } lmu_mode_e;
endpackage

// File: rtl/lmu_lane_mult.sv
module lmu_lane_mult #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]          a,
  input  logic [LANE_W-1:0]          b,
  output logic signed [2*LANE_W-1:0] prod
);
  localparam int PROD_W = 2 * LANE_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  // sign-extend to full product width so the product keeps its sign
  assign a_ext = {{LANE_W{a[LANE_W-1]}}, a};
  assign b_ext = {{LANE_W{b[LANE_W-1]}}, b};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/lmu_interleave.sv
module lmu_interleave #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a,
  input  logic [LANE_W*LANES-1:0] b,
  input  logic                    sel_high,
  output logic [LANE_W*LANES-1:0] ilv
);
  localparam int HALF = LANES / 2;

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    assign ilv[(2*k)*LANE_W +: LANE_W] =
      sel_high ? a[(k+HALF)*LANE_W +: LANE_W] : a[k*LANE_W +: LANE_W];
    assign ilv[(2*k+1)*LANE_W +: LANE_W] =
      sel_high ? b[(k+HALF)*LANE_W +: LANE_W] : b[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lmu_combine.sv
module lmu_combine
  import lmu_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANES*2*LANE_W-1:0] prods,
  input  logic [LANE_W*LANES-1:0]   ilv,
  input  logic [MODE_W-1:0]         mode,
  output logic [LANE_W*LANES-1:0]   result
);
  localparam int PROD_W = 2 * LANE_W;
  localparam int DATA_W = LANE_W * LANES;
  localparam int PAIRS  = LANES / 2;

  logic [DATA_W-1:0] lo_vec;
  logic [DATA_W-1:0] hi_vec;
  logic [DATA_W-1:0] sum_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign lo_vec[i*LANE_W +: LANE_W] = prods[i*PROD_W +: LANE_W];
    assign hi_vec[i*LANE_W +: LANE_W] = prods[i*PROD_W + LANE_W +: LANE_W];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_sum
    // modular sum: no saturation on the pair total
    assign sum_vec[p*PROD_W +: PROD_W] =
      prods[(2*p)*PROD_W +: PROD_W] + prods[(2*p+1)*PROD_W +: PROD_W];
  end

  always_comb begin
    case (mode)
      MODE_MUL_LO:                result = lo_vec;
      MODE_MUL_HI:                result = hi_vec;
      MODE_MADD:                  result = sum_vec;
      MODE_ILV_LO, MODE_ILV_HI:   result = ilv;
      default:                    result = '0;
    endcase
  end
endmodule

// File: rtl/lane_mul_unit.sv
module lane_mul_unit
  import lmu_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [MODE_W-1:0]        in_mode,
  input  logic [LANE_W*LANES-1:0]  in_a,
  input  logic [LANE_W*LANES-1:0]  in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANE_W*LANES-1:0]  out_data
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int PROD_W = 2 * LANE_W;
  localparam int PVEC_W = PROD_W * LANES;

  // ---------------- stage 0: lane multipliers and word interleave
  logic [PVEC_W-1:0] prod_vec;
  logic [DATA_W-1:0] ilv_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [PROD_W-1:0] lane_prod;
    lmu_lane_mult #(.LANE_W(LANE_W)) u_mult (
      .a    (in_a[i*LANE_W +: LANE_W]),
      .b    (in_b[i*LANE_W +: LANE_W]),
      .prod (lane_prod)
    );
    assign prod_vec[i*PROD_W +: PROD_W] = lane_prod;
  end

  lmu_interleave #(.LANE_W(LANE_W), .LANES(LANES)) u_ilv (
    .a        (in_a),
    .b        (in_b),
    .sel_high (in_mode == MODE_ILV_HI),
    .ilv      (ilv_vec)
  );

  // ---------------- pipeline advance control
  logic s1_v, s2_v;
  logic s1_load, s2_load;

  assign s2_load  = !s2_v || out_ready;
  assign s1_load  = !s1_v || s2_load;
  assign in_ready = s1_load;

  // ---------------- stage 1 registers
  logic [PVEC_W-1:0] s1_prod;
  logic [DATA_W-1:0] s1_ilv;
  logic [MODE_W-1:0] s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_prod <= '0;
      s1_ilv  <= '0;
      s1_mode <= '0;
    end else if (s1_load) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_prod <= prod_vec;
        s1_ilv  <= ilv_vec;
        s1_mode <= in_mode;
      end
    end
  end

  // ---------------- stage 1 to 2: result selection
  logic [DATA_W-1:0] s1_result;

  lmu_combine #(.LANE_W(LANE_W), .LANES(LANES)) u_comb (
    .prods  (s1_prod),
    .ilv    (s1_ilv),
    .mode   (s1_mode),
    .result (s1_result)
  );

  // ---------------- stage 2 registers
  logic [DATA_W-1:0] s2_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v    <= 1'b0;
      s2_data <= '0;
    end else if (s2_load) begin
      s2_v <= s1_v;
      if (s1_v) s2_data <= s1_result;
    end
  end

  assign out_valid = s2_v;
  assign out_data  = s2_data;
endmodule

// File: rtl/lmu_checker.sv
module lmu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  // R1: pipeline empty right after a reset cycle
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> (!out_valid && in_ready))
    else $error("a_r1_reset_empty");

  // R9: stalled result keeps its valid
  a_r9_valid_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid)
    else $error("a_r9_valid_held");

  // R9: stalled result keeps its data
  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data))
    else $error("a_r9_data_stable");

  // R9: a ready consumer never blocks the input
  a_r9_ready_pass: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready)
    else $error("a_r9_ready_pass");

  // R8: accepted input with a ready consumer appears after two edges
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid)
    else $error("a_r8_latency");
endmodule

bind lane_mul_unit lmu_checker #(.DATA_W(LANE_W*LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/lane_mul_unit_tb.sv
module lane_mul_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = 3'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;

  logic [63:0] exp_q[$];
  logic [2:0]  mode_q[$];

  always #10 clk = ~clk;  // 50 MHz

  lane_mul_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] lane_prod(logic [63:0] a, logic [63:0] b, int i);
    longint pa = longint'($signed(a[16*i +: 16]));
    longint pb = longint'($signed(b[16*i +: 16]));
    longint p  = pa * pb;
    return p[31:0];
  endfunction

  function automatic logic [63:0] model(logic [2:0] m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    case (m)
      3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_prod(a, b, i)[15:0];
      3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_prod(a, b, i)[31:16];
      3'd2: begin
        r[31:0]  = lane_prod(a, b, 0) + lane_prod(a, b, 1);
        r[63:32] = lane_prod(a, b, 2) + lane_prod(a, b, 3);
      end
      3'd3: r = {b[31:16], a[31:16], b[15:0], a[15:0]};
      3'd4: r = {b[63:48], a[63:48], b[47:32], a[47:32]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, observe handshakes before the next posedge
  task automatic step(bit v, logic [2:0] m, logic [63:0] a, logic [63:0] b, bit ordy,
                      logic [63:0] exp_override = '0, bit use_override = 0);
    @(negedge clk);
    in_valid  = v;
    in_mode   = m;
    in_a      = a;
    in_b      = b;
    out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected output", out_data, '0);
        errors += (out_data == '0) ? 1 : 0;
      end else begin
        logic [63:0] e  = exp_q.pop_front();
        logic [2:0]  em = mode_q.pop_front();
        check(req_of(em), out_data, e);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(use_override ? exp_override : model(m, a, b));
      mode_q.push_back(m);
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 10; n++) step(0, 3'd0, '0, '0, 1);
  endtask

  task automatic run_all();
    logic [63:0] xa, xb, held;
    xa = 64'h00A4_03F3_2112_01AC;
    xb = 64'h00D8_0AB7_0137_0006;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // R2, R3: known products, literal expectations
    step(1, 3'd0, xa, xb, 1, 64'h8A60_50B5_2CDE_0A08, 1);
    step(1, 3'd1, xa, xb, 1, 64'h0000_002A_0028_0000, 1);
    // R3: negative lanes keep their sign in the high half
    step(1, 3'd1, 64'h8000_FFFF_7FFF_FFFF, 64'h8000_0001_8000_7FFF, 1,
         64'h4000_FFFF_C000_FFFF, 1);
    // R4: wrap of 0x8000 pairs
    step(1, 3'd2, {4{16'h8000}}, {4{16'h8000}}, 1, 64'h8000_0000_8000_0000, 1);
    step(1, 3'd2, 64'h0001_FFFF_0003_0002, 64'h0005_0002_0004_0007, 1,
         64'h0000_0003_0000_001A, 1);
    // R5, R6: rejoin the halves of the known example
    step(1, 3'd3, 64'h8A60_50B5_2CDE_0A08, 64'h0000_002A_0028_0000, 1,
         64'h0028_2CDE_0000_0A08, 1);
    step(1, 3'd4, 64'h8A60_50B5_2CDE_0A08, 64'h0000_002A_0028_0000, 1,
         64'h0000_8A60_002A_50B5, 1);
    // R7: unused codes
    step(1, 3'd5, xa, xb, 1, 64'd0, 1);
    step(1, 3'd7, xa, xb, 1, 64'd0, 1);
    drain();

    // R8: output appears two cycles after the input cycle
    step(1, 3'd0, xa, xb, 1);
    step(0, 3'd0, '0, '0, 1);
    check("R8 not valid after one cycle", {63'd0, out_valid}, 64'd0);
    step(0, 3'd0, '0, '0, 1);
    drain();

    // R9: stall holds data, input blocks after two accepts, order kept
    step(1, 3'd2, xa, xb, 0);
    step(1, 3'd0, xb, xa, 0);
    step(1, 3'd1, xa, xa, 0);
    check("R9 in_ready low when full", {63'd0, in_ready}, 64'd0);
    check("R9 out_valid held", {63'd0, out_valid}, 64'd1);
    held = out_data;
    step(1, 3'd4, xa, xb, 0);
    check("R9 out_data stable", out_data, held);
    check("R9 in_ready still low", {63'd0, in_ready}, 64'd0);
    drain();

    // random mix with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) ra[15:0] = 16'h8000;
      if ($urandom_range(0, 7) == 0) rb[15:0] = 16'h8000;
      step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), ra, rb,
           $urandom_range(0, 3) != 0);
    end
    drain();
    check("R9 nothing left in flight", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h1bad_5eed));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule